// File: doc/BRIEF.md
# Keyed Register Write Gate

This block sits between a host register bus and a peripheral's register file and decides which host writes may reach it. Every write to an address other than the gate's own key register is blocked unless a 16-bit key has first been written to the key register, and unless the previous accepted write has finished committing into the slow clock domain. An unlock covers a single write. The host should wait for the ready flag, write the key, poll the unlocked flag, wait for ready again, and then issue the protected write.

The gate owns two status views. The key register reads back the unlocked flag and a sticky error flag that records a rejected write. The control offset passes through the downstream read data, with the ready flag overlaid on one bit. All other reads go straight through to the downstream register file.

Top module: `write_unlock_gate`

## Requirements
- R1: After reset the gate is locked, the error flag is clear, ready reads 1, and no downstream write strobe is issued.
- R2: A write to the key register (offset 0x3C) whose low 16 bits equal 0xA55A unlocks the gate. From the next cycle, bit 31 of a read at offset 0x3C is 1. The upper data bits are ignored.
- R3: A write of any other value to the key register locks the gate. Bit 31 of the key register reads 0 afterwards.
- R4: A write to any offset other than 0x3C, while the gate is unlocked and ready, drives dn_we_o high in the same cycle. dn_addr_o and dn_wdata_o carry the bus address and data.
- R5: An accepted protected write consumes the unlock. From the next cycle, bit 31 of the key register reads 0.
- R6: After an accepted write, ready (bit 7 of a read at offset 0x00) reads 0 for exactly COMMIT_CYCLES cycles and then returns to 1.
- R7: A protected write while the gate is locked produces no strobe and sets the sticky error flag. The error flag is bit 0 of the key register.
- R8: A protected write while ready is 0 produces no strobe and sets the error flag. It leaves the unlock in place.
- R9: A read of the key register returns the error flag and clears it from the next cycle.
- R10: Writes to the key register are always accepted, even while ready is 0, and are never forwarded downstream.
- R11: A read at an offset other than 0x3C returns dn_rdata_i unchanged, except that at offset 0x00 bit 7 is replaced by ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Host write strobe |
| bus_re_i | input | 1 | Host read strobe |
| bus_addr_i | input | ADDR_W | Host byte offset |
| bus_wdata_i | input | DATA_W | Host write data |
| bus_rdata_o | output | DATA_W | Host read data (combinational) |
| dn_we_o | output | 1 | Gated write strobe to the register file |
| dn_re_o | output | 1 | Read strobe to the register file |
| dn_addr_o | output | ADDR_W | Offset to the register file |
| dn_wdata_o | output | DATA_W | Write data to the register file |
| dn_rdata_i | input | DATA_W | Read data from the register file |

## Verification
The checker examines the following on every cycle:
- A forwarded strobe always clears the unlock and drops ready on the following cycle.
- Ready only ever falls after a forwarded strobe.
- A key-register write is never forwarded.
- A matching key always unlocks the gate.
- Every blocked protected write raises the error flag.

Only the bench's scenarios can show the observable results as the host sees them:
- The exact length of the busy window.
- That a rejected write keeps an existing unlock.
- That the error flag clears on a read.
- The read-data overlay at the control offset.
- The effect of reset in the middle of a run.

// File: rtl/wug_pkg.sv
package wug_pkg;
  localparam int unsigned ADDR_W_DEF     = 8;
  localparam int unsigned DATA_W_DEF     = 32;
  localparam int unsigned KEY_W_DEF      = 16;
  localparam int unsigned COMMIT_DEF     = 4;
  localparam logic [15:0] KEY_DEF        = 16'hA55A;
  localparam logic [7:0]  KEY_OFFS_DEF   = 8'h3C;
  localparam logic [7:0]  CTRL_OFFS_DEF  = 8'h00;
  localparam int unsigned READY_BIT_DEF  = 7;
  localparam int unsigned UNLOCK_BIT_DEF = 31;
  localparam int unsigned ERR_BIT_DEF    = 0;
endpackage

// File: rtl/wug_key_guard.sv
module wug_key_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_wr_i,
  input  logic key_match_i,
  input  logic accept_i,
  input  logic reject_i,
  input  logic err_clr_i,
  output logic unlocked_o,
  output logic err_o
);
  logic unlocked_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
    end else if (key_wr_i) begin
      unlocked_q <= key_match_i;
    end else if (accept_i) begin
      unlocked_q <= 1'b0;  // one write per key
    end
  end

  // a rejection in the same cycle as a clearing read keeps the flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (reject_i) begin
      err_q <= 1'b1;
    end else if (err_clr_i) begin
      err_q <= 1'b0;
    end
  end

  assign unlocked_o = unlocked_q;
  assign err_o      = err_q;
endmodule

// File: rtl/wug_commit_timer.sv
module wug_commit_timer #(
  parameter int unsigned COMMIT_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ready_o
);
  generate
    if (COMMIT_CYCLES == 0) begin : g_no_wait
      assign ready_o = 1'b1;
    end else begin : g_wait
      localparam int unsigned CNT_W = $clog2(COMMIT_CYCLES + 1);
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMIT_CYCLES);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (start_i) begin
          cnt_q <= CNT_LOAD;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      assign ready_o = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/write_unlock_gate.sv
module write_unlock_gate
  import wug_pkg::*;
#(
  parameter int unsigned ADDR_W        = ADDR_W_DEF,
  parameter int unsigned DATA_W        = DATA_W_DEF,
  parameter int unsigned KEY_W         = KEY_W_DEF,
  parameter int unsigned COMMIT_CYCLES = COMMIT_DEF,
  parameter logic [KEY_W-1:0]  KEY        = KEY_DEF,
  parameter logic [ADDR_W-1:0] KEY_OFFS   = KEY_OFFS_DEF,
  parameter logic [ADDR_W-1:0] CTRL_OFFS  = CTRL_OFFS_DEF,
  parameter int unsigned READY_BIT     = READY_BIT_DEF,
  parameter int unsigned UNLOCK_BIT    = UNLOCK_BIT_DEF,
  parameter int unsigned ERR_BIT       = ERR_BIT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              dn_we_o,
  output logic              dn_re_o,
  output logic [ADDR_W-1:0] dn_addr_o,
  output logic [DATA_W-1:0] dn_wdata_o,
  input  logic [DATA_W-1:0] dn_rdata_i
);
  logic is_key, is_ctrl, key_wr, key_match, prot_wr;
  logic accept, reject, err_clr;
  logic unlocked, ready, err_flag;
  logic [DATA_W-1:0] status_word, ctrl_word;

  assign is_key    = (bus_addr_i == KEY_OFFS);
  assign is_ctrl   = (bus_addr_i == CTRL_OFFS);
  assign key_wr    = bus_we_i & is_key;
  assign key_match = (bus_wdata_i[KEY_W-1:0] == KEY);
  assign prot_wr   = bus_we_i & ~is_key;
  assign accept    = prot_wr & unlocked & ready;
  assign reject    = prot_wr & ~accept;
  assign err_clr   = bus_re_i & is_key;

  wug_key_guard u_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .key_wr_i    (key_wr),
    .key_match_i (key_match),
    .accept_i    (accept),
    .reject_i    (reject),
    .err_clr_i   (err_clr),
    .unlocked_o  (unlocked),
    .err_o       (err_flag)
  );

  wug_commit_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .ready_o (ready)
  );

  always_comb begin
    status_word             = '0;
    status_word[UNLOCK_BIT] = unlocked;
    status_word[ERR_BIT]    = err_flag;
    ctrl_word               = dn_rdata_i;
    ctrl_word[READY_BIT]    = ready;
  end

  assign bus_rdata_o = is_key  ? status_word :
                       is_ctrl ? ctrl_word   : dn_rdata_i;

  assign dn_we_o    = accept;
  assign dn_re_o    = bus_re_i & ~is_key;
  assign dn_addr_o  = bus_addr_i;
  assign dn_wdata_o = bus_wdata_i;
endmodule

// File: rtl/write_unlock_gate_chk.sv
module write_unlock_gate_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned KEY_W  = 16,
  parameter logic [KEY_W-1:0]  KEY      = 16'hA55A,
  parameter logic [ADDR_W-1:0] KEY_OFFS = 8'h3C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              dn_we_o,
  input logic              unlocked_i,
  input logic              ready_i,
  input logic              err_i
);
  p_strobe_consumes_unlock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_we_o |=> !unlocked_i);

  p_strobe_starts_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_we_o |=> !ready_i);

  p_ready_falls_after_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_i) |-> $past(dn_we_o));

  p_key_not_forwarded_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == KEY_OFFS) |-> !dn_we_o);

  p_key_unlocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == KEY_OFFS && bus_wdata_i[KEY_W-1:0] == KEY) |=> unlocked_i);

  p_reject_sets_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i != KEY_OFFS && !dn_we_o) |=> err_i);
endmodule

bind write_unlock_gate write_unlock_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY), .KEY_OFFS(KEY_OFFS)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .dn_we_o     (dn_we_o),
  .unlocked_i  (unlocked),
  .ready_i     (ready),
  .err_i       (err_flag)
);

// File: tb/write_unlock_gate_tb_top.sv
module write_unlock_gate_tb_top;
  localparam int unsigned COMMIT = 4;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic        exp_we;
    logic [31:0] exp_rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 8'h00, 32'h0,         1'b0, 32'hC0DE_0080, 4'd1},  // R1 ready at reset
    '{OP_RD, 8'h3C, 32'h0,         1'b0, 32'h0000_0000, 4'd1},  // R1 locked, no error
    '{OP_WR, 8'h10, 32'h11,        1'b0, 32'h0,         4'd7},  // R7 locked write blocked
    '{OP_RD, 8'h3C, 32'h0,         1'b0, 32'h0000_0001, 4'd7},  // R7 error flag set
    '{OP_RD, 8'h3C, 32'h0,         1'b0, 32'h0000_0000, 4'd9},  // R9 cleared by read
    '{OP_WR, 8'h3C, 32'hA55A,      1'b0, 32'h0,         4'd2},  // R2 key
    '{OP_RD, 8'h3C, 32'h0,         1'b0, 32'h8000_0000, 4'd2},  // R2 unlocked
    '{OP_WR, 8'h3C, 32'h1234,      1'b0, 32'h0,         4'd3},  // R3 wrong key
    '{OP_RD, 8'h3C, 32'h0,         1'b0, 32'h0000_0000, 4'd3},  // R3 locked again
    '{OP_WR, 8'h3C, 32'hFFFF_A55A, 1'b0, 32'h0,         4'd2},  // R2 upper bits ignored
    '{OP_WR, 8'h20, 32'hCAFE,      1'b1, 32'h0,         4'd4},  // R4 accepted
    '{OP_RD, 8'h3C, 32'h0,         1'b0, 32'h0000_0000, 4'd5},  // R5 unlock consumed
    '{OP_RD, 8'h00, 32'h0,         1'b0, 32'hC0DE_0000, 4'd6},  // R6 busy
    '{OP_WR, 8'h3C, 32'hA55A,      1'b0, 32'h0,         4'd10}, // R10 key while busy
    '{OP_WR, 8'h24, 32'h5,         1'b0, 32'h0,         4'd8},  // R8 not ready
    '{OP_RD, 8'h3C, 32'h0,         1'b0, 32'h8000_0001, 4'd8},  // R8 unlock kept, err set
    '{OP_RD, 8'h00, 32'h0,         1'b0, 32'hC0DE_0080, 4'd6},  // R6 ready again
    '{OP_RD, 8'h3C, 32'h0,         1'b0, 32'h8000_0000, 4'd9},  // R9 err cleared
    '{OP_RD, 8'h10, 32'h0,         1'b0, 32'hC0DE_0090, 4'd11}, // R11 passthrough
    '{OP_WR, 8'h00, 32'h1,         1'b1, 32'h0,         4'd4}   // R4 control offset protected
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, dn_wdata, dn_rdata;
  logic        dn_we, dn_re;
  logic [7:0]  dn_addr;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  assign dn_rdata = 32'hC0DE_0080 | 32'(dn_addr);

  write_unlock_gate #(.COMMIT_CYCLES(COMMIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .dn_we_o(dn_we), .dn_re_o(dn_re), .dn_addr_o(dn_addr), .dn_wdata_o(dn_wdata),
    .dn_rdata_i(dn_rdata)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive after falling edge, sample 2 ns later, commit on rising edge
  task automatic apply(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = (op == OP_WR); re = (op == OP_RD); addr = a; wdata = d;
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1", "dn_we after reset", 32'(dn_we), 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      apply(VECS[i].op, VECS[i].addr, VECS[i].data);
      check(tag, $sformatf("vec %0d dn_we", i), 32'(dn_we), 32'(VECS[i].exp_we));
      if (VECS[i].op == OP_RD)
        check(tag, $sformatf("vec %0d rdata", i), rdata, VECS[i].exp_rd);
      if (VECS[i].exp_we) begin
        check(tag, $sformatf("vec %0d dn_addr", i), 32'(dn_addr), 32'(VECS[i].addr));
        check(tag, $sformatf("vec %0d dn_wdata", i), dn_wdata, VECS[i].data);
      end
    end

    // R6: count busy cycles after the last accepted write
    begin
      int busy = 0;
      for (int k = 0; k < 3 * COMMIT + 2; k++) begin
        apply(OP_RD, 8'h00, 32'h0);
        if (rdata[7]) break;
        busy++;
      end
      check("R6", "busy window length", 32'(busy), 32'(COMMIT));
    end

    // R3: near-miss key leaves the gate locked
    apply(OP_WR, 8'h3C, 32'hA55B);
    apply(OP_RD, 8'h3C, 32'h0);
    check("R3", "near-miss key", rdata, 32'h0);

    // R10: key write not forwarded, R11 no read strobe at key offset
    apply(OP_WR, 8'h3C, 32'hA55A);
    check("R10", "key write strobe", 32'(dn_we), 32'd0);
    apply(OP_RD, 8'h3C, 32'h0);
    check("R11", "key read not forwarded", 32'(dn_re), 32'd0);

    // R1: reset mid-run drops the unlock
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    rst_n = 1'b0;
    #2;
    rst_n = 1'b1;
    apply(OP_RD, 8'h3C, 32'h0);
    check("R1", "unlock after reset", rdata, 32'h0);
    apply(OP_RD, 8'h00, 32'h0);
    check("R1", "ready after reset", rdata, 32'hC0DE_0080);

    apply(OP_IDLE, 8'h00, 32'h0);
    finish_run();
  end
endmodule